// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel Controller

A memory-mapped pulse-width generator with a parameterised number of channels. Each channel has one 32-bit control word and sits in its own 1 KiB window of the address space. Every clock, the channel adds a frequency increment to a phase accumulator. Each overflow of the accumulator ends one output period. The output duty comes from comparing the accumulator's top eight bits with an 8-bit threshold. A larger threshold gives a shorter high phase, so software programs the threshold as 255 minus the wanted duty scaled to 255.

Software writes new settings into a staged copy. They reach the running logic only after a commit, which software requests by setting the update bit. The update bit clears itself once the staged increment and threshold have been copied into the active registers. This copy happens on the next clock while the channel is disabled, or on the next accumulator overflow while it is running. The setting of the enable bit does not carry staged values. A channel enabled without a prior commit runs on whatever values are already active.

Top module: `pwm_phase_ctrl`

## Requirements
- R1: After reset, every control word reads as zero and every PWM output is low.
- R2: Control word layout is as follows. Bit 31 is enable and bit 30 is the update request. Bits [8+INC_W-1:8] hold the increment and bits [7:0] hold the threshold. All other bits read as zero. A read returns the staged increment and threshold, the enable bit, and the update bit, which stays set while a commit is pending.
- R3: Channel k is written and read at byte address k*0x400. An address with a nonzero offset inside a window, or one that selects a channel index of N_CH or above, writes nothing and reads as zero.
- R4: While running, the accumulator (INC_W bits) grows by the active increment each clock. The output period is therefore 2^INC_W / increment clocks.
- R5: While enabled, the output is high exactly when the accumulator's top 8 bits are greater than or equal to the active threshold.
- R6: Writing new increment or threshold values without the update bit leaves the output unchanged.
- R7: Enabling a channel without a prior commit runs it on the active values already held, not on the staged ones.
- R8: A commit requested while disabled completes on the next clock. A commit requested while running completes at the next accumulator overflow. In both cases the update bit then reads 0.
- R9: While disabled, the output is low and the accumulator is held at zero, so each enable starts a new period from phase zero.
- R10: If a pending commit completes in the same cycle as a new write, the commit copies the staged values held before that write. The pending flag then follows only the new write's update bit.
- R11: Channels are independent: writing one channel changes neither another channel's control word nor its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | ADDR_W | Byte address of the control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | N_CH | One PWM output per channel |

## Verification
The collision of interest is a commit completing in the same cycle as a new register write to the same channel. The bench provokes it by writing a disabled channel with the update bit set and then writing it again on the very next clock with different values and no update bit. The pending commit and the second write therefore share one edge. The result is judged at the ports. The readback must show the second write's values with nothing pending. After enabling, the output's high count over a fixed window must match the first write's increment and threshold, not the second's.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned UPD_BIT   = 30;
  localparam int unsigned INC_LSB   = 8;
  localparam int unsigned THR_W     = 8;
  localparam int unsigned WIN_SHIFT = 10;
  localparam int unsigned WORD_W    = 32;

  typedef logic [THR_W-1:0] thr_t;
endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
  import pwm_phase_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CH-1:0]   wr_sel_o,
  output logic [N_CH-1:0]   rd_sel_o
);
  localparam int unsigned IDX_W = ADDR_W - WIN_SHIFT;

  logic [IDX_W-1:0] idx;
  logic             off_zero;
  logic             in_range;

  assign idx      = addr_i[ADDR_W-1:WIN_SHIFT];
  assign off_zero = (addr_i[WIN_SHIFT-1:0] == '0);
  assign in_range = (32'(idx) < N_CH);

  for (genvar k = 0; k < N_CH; k++) begin : g_sel
    assign rd_sel_o[k] = off_zero && in_range && (idx == IDX_W'(k));
    assign wr_sel_o[k] = wr_en_i && rd_sel_o[k];
  end

  // R3
  wr_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel_o));
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_phase_pkg::*;
#(
  parameter int unsigned INC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              wrap_i,
  output logic              en_o,
  output logic [INC_W-1:0]  inc_act_o,
  output thr_t              thr_act_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic             en_q, en_d;
  logic             pend_q, pend_d;
  logic [INC_W-1:0] inc_stg_q, inc_stg_d;
  thr_t             thr_stg_q, thr_stg_d;
  logic [INC_W-1:0] inc_act_q, inc_act_d;
  thr_t             thr_act_q, thr_act_d;
  logic             commit;

  // Commit on the next clock when idle, at an overflow when running.
  assign commit = pend_q && (!en_q || wrap_i);

  always_comb begin
    en_d      = en_q;
    inc_stg_d = inc_stg_q;
    thr_stg_d = thr_stg_q;
    pend_d    = pend_q && !commit;
    if (wr_i) begin
      en_d      = wdata_i[EN_BIT];
      inc_stg_d = wdata_i[INC_LSB +: INC_W];
      thr_stg_d = wdata_i[THR_W-1:0];
      pend_d    = pend_d || wdata_i[UPD_BIT];
    end
    inc_act_d = commit ? inc_stg_q : inc_act_q;
    thr_act_d = commit ? thr_stg_q : thr_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      inc_stg_q <= '0;
      thr_stg_q <= '0;
      inc_act_q <= '0;
      thr_act_q <= '0;
    end else begin
      en_q      <= en_d;
      pend_q    <= pend_d;
      inc_stg_q <= inc_stg_d;
      thr_stg_q <= thr_stg_d;
      inc_act_q <= inc_act_d;
      thr_act_q <= thr_act_d;
    end
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[EN_BIT]           = en_q;
    rdata_o[UPD_BIT]          = pend_q;
    rdata_o[INC_LSB +: INC_W] = inc_stg_q;
    rdata_o[THR_W-1:0]        = thr_stg_q;
  end

  assign en_o      = en_q;
  assign inc_act_o = inc_act_q;
  assign thr_act_o = thr_act_q;

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> ($stable(inc_act_q) && $stable(thr_act_q)));

  // R8
  idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !en_q && !wr_i) |=> !pend_q);
endmodule

// File: rtl/pwm_phase_core.sv
module pwm_phase_core
  import pwm_phase_pkg::*;
#(
  parameter int unsigned INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  input  thr_t             thr_i,
  output logic             wrap_o,
  output logic             pwm_o
);
  logic [INC_W-1:0] acc_q, acc_d;
  logic [INC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap_o = en_i && sum[INC_W];

  always_comb begin
    acc_d = '0;
    if (en_i) acc_d = sum[INC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign pwm_o = en_i && (acc_q[INC_W-1 -: THR_W] >= thr_i);

  // R9
  idle_phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && $past(!en_i)) |-> (acc_q == '0));
endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl
  import pwm_phase_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned INC_W  = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [N_CH-1:0]   wr_sel;
  logic [N_CH-1:0]   rd_sel;
  logic [N_CH-1:0]   ch_en;
  logic [N_CH-1:0]   ch_wrap;
  logic [31:0]       ch_rdata [N_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_addr_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [INC_W-1:0] inc_act;
    thr_t             thr_act;

    pwm_chan_regs #(.INC_W(INC_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_i      (wr_sel[k]),
      .wdata_i   (wdata_i),
      .wrap_i    (ch_wrap[k]),
      .en_o      (ch_en[k]),
      .inc_act_o (inc_act),
      .thr_act_o (thr_act),
      .rdata_o   (ch_rdata[k])
    );

    pwm_phase_core #(.INC_W(INC_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .en_i   (ch_en[k]),
      .inc_i  (inc_act),
      .thr_i  (thr_act),
      .wrap_o (ch_wrap[k]),
      .pwm_o  (pwm_o[k])
    );

    // R9
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      !ch_en[k] |-> !pwm_o[k]);
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (rd_sel[k]) rdata_o = ch_rdata[k];
    end
  end
endmodule

// File: tb/pwm_phase_ctrl_tb.sv
module pwm_phase_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH   = 2;
  localparam int INC_W  = 16;
  localparam int ADDR_W = 12;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] UPD = 32'h4000_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic [N_CH-1:0]   pwm;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_phase_ctrl #(.N_CH(N_CH), .INC_W(INC_W), .ADDR_W(ADDR_W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  function automatic logic [31:0] word(logic [15:0] inc, logic [7:0] thr);
    return {8'h00, inc, thr};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic count_high(int ch, int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c += int'(pwm[ch]);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h000, d); check("R1 ch0 word", d, 32'h0);
    rd(12'h400, d); check("R1 ch1 word", d, 32'h0);
    check("R1 outputs", 32'(pwm), 32'h0);
  endtask

  task automatic t_enable_no_commit;
    logic [31:0] d; int c;
    wr(12'h000, EN | word(16'h4000, 8'h80));
    rd(12'h000, d); check("R2 readback staged", d, EN | word(16'h4000, 8'h80));
    count_high(0, 40, c);
    check("R7 enable without commit uses zero actives", 32'(c), 32'd40);
    wr(12'h000, word(16'h4000, 8'h80));
  endtask

  task automatic t_idle_commit;
    logic [31:0] d; int c;
    wr(12'h000, UPD | word(16'h4000, 8'h80));
    rd(12'h000, d); check("R8 update pending", d, UPD | word(16'h4000, 8'h80));
    idle(1);
    rd(12'h000, d); check("R8 update self-clears when idle", d, word(16'h4000, 8'h80));
    wr(12'h000, EN | word(16'h4000, 8'h80));
    count_high(0, 40, c);
    check("R5 duty thr=0x80 period 4", 32'(c), 32'd20);
  endtask

  task automatic t_running_change;
    logic [31:0] d; int c;
    wr(12'h000, EN | word(16'h4000, 8'hC0));
    rd(12'h000, d); check("R2 staged thr visible", d, EN | word(16'h4000, 8'hC0));
    count_high(0, 40, c);
    check("R6 uncommitted change ignored", 32'(c), 32'd20);
    wr(12'h000, EN | UPD | word(16'h4000, 8'hC0));
    rd(12'h000, d); check("R8 pending while running", d[30], 32'h1);
    idle(6);
    rd(12'h000, d); check("R8 commit at overflow clears", d[30], 32'h0);
    count_high(0, 40, c);
    check("R5 duty thr=0xC0", 32'(c), 32'd10);
  endtask

  task automatic t_threshold_max;
    int c;
    wr(12'h000, EN | UPD | word(16'h0100, 8'hFF));
    idle(8);
    count_high(0, 256, c);
    check("R4 R5 inc=0x100 thr=0xFF one high per 256", 32'(c), 32'd1);
  endtask

  task automatic t_disable;
    int c;
    wr(12'h000, word(16'h0100, 8'hFF));
    count_high(0, 20, c);
    check("R9 low while disabled", 32'(c), 32'd0);
    wr(12'h000, EN | word(16'h0100, 8'hFF));
    count_high(0, 250, c);
    check("R9 restart from phase zero", 32'(c), 32'd0);
    wr(12'h000, word(16'h0100, 8'hFF));
  endtask

  task automatic t_collision;
    logic [31:0] d; int c;
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h000; wdata = UPD | word(16'h4000, 8'h80);
    @(negedge clk);
    wdata = word(16'h2000, 8'h40);
    @(negedge clk);
    wr_en = 1'b0;
    rd(12'h000, d); check("R10 readback after collision", d, word(16'h2000, 8'h40));
    wr(12'h000, EN | word(16'h2000, 8'h40));
    count_high(0, 40, c);
    check("R10 commit took pre-write values", 32'(c), 32'd20);
    wr(12'h000, word(16'h2000, 8'h40));
  endtask

  task automatic t_second_channel;
    logic [31:0] d; int c;
    wr(12'h400, UPD | word(16'h8000, 8'h80));
    idle(2);
    wr(12'h400, EN | word(16'h8000, 8'h80));
    count_high(1, 40, c);
    check("R11 ch1 duty", 32'(c), 32'd20);
    check("R11 ch0 stays low", 32'(pwm[0]), 32'h0);
    rd(12'h000, d); check("R11 ch0 word untouched", d, word(16'h2000, 8'h40));
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(12'h004, EN | UPD | word(16'h1234, 8'h56));
    wr(12'h800, EN | UPD | word(16'h1234, 8'h56));
    rd(12'h000, d); check("R3 offset write ignored", d, word(16'h2000, 8'h40));
    rd(12'h400, d); check("R3 ch1 untouched", d, EN | word(16'h8000, 8'h80));
    rd(12'h004, d); check("R3 offset reads zero", d, 32'h0);
    rd(12'h800, d); check("R3 out-of-range reads zero", d, 32'h0);
    check("R3 ch0 output still low", 32'(pwm[0]), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_enable_no_commit();
    t_idle_commit();
    t_running_change();
    t_threshold_max();
    t_disable();
    t_collision();
    t_second_channel();
    t_decode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule